// File: doc/BRIEF.md
# Periodic Battery-Low Monitor

This block decides when a backup battery is measured and remembers the verdict. An external comparator reports whether the battery is under its low threshold of roughly 2.5 V. The block asks for a measurement with a sample request and captures the comparator answer at the end of a fixed settling window. It holds the result in a sticky flag, which drives the enable of an open-drain battery-low line.

A check starts each time the synchronised supply-nominal input goes from not nominal to nominal. Further checks follow at a fixed interval while the supply stays nominal. The interval is counted in pulses of a slow clock-enable tick, not in clock cycles. Its length is a parameter: the default is one day of 1 Hz ticks, and a bench uses a few ticks. While the supply is not nominal, no check runs and the interval count is held at zero. The flag changes only when a check completes, so a low verdict persists until a later check, at power-up or periodic, reports a healthy battery.

Top module: `batt_low_monitor`

## Requirements
- R1: After reset, `sampleReq` is 0 and `pullLowEn` is 0 (the battery-low line is released).
- R2: When `supplyOk` is sampled 1 at a clock edge while the block is unpowered, `sampleReq` is 1 from that edge on for exactly SETTLE_CYCLES consecutive cycles, then falls.
- R3: At the clock edge that ends a check window (the last cycle with `sampleReq` 1), `battBelow` is captured. From that edge on, `pullLowEn` equals the captured value, where 1 means the battery is low and the line is pulled low.
- R4: `battBelow` has no effect on `pullLowEn` outside the last cycle of a completed check.
- R5: While the supply stays nominal, a new check begins at the edge that samples the INTERVAL_TICKS-th tick counted since the previous power-up check, or since the previous periodic check began.
- R6: While `supplyOk` is 0, `sampleReq` is 0 from the next cycle on, ticks are not counted, and the tick count restarts from zero at the next power-up.
- R7: If `supplyOk` drops during a check window, the check is abandoned: `pullLowEn` keeps its previous value and `sampleReq` falls on the next cycle.
- R8: A set flag clears only when a later completed check, either at power-up or periodic, captures `battBelow` = 0.
- R9: Clock cycles without `tick` do not advance the interval, so no periodic check starts without ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| supplyOk | input | 1 | Synchronised main-supply-nominal indication |
| tick | input | 1 | Clock enable for interval timing, one cycle per tick |
| battBelow | input | 1 | Comparator result, 1 = battery below threshold |
| sampleReq | output | 1 | Request to the comparator to measure the battery |
| pullLowEn | output | 1 | Open-drain enable, 1 = battery-low line pulled low |

## Verification
The hardest situation to reach is a supply loss in the middle of a periodic check while the battery reads low. Reaching it needs a nominal supply for a full tick interval and then a drop within a short window. The bench shrinks the interval to five ticks, feeds ticks on consecutive cycles to start the check at a known edge, and then drops the supply one cycle later. A randomised phase with frequent short supply drops and bursty ticks then reaches the same corner at many other offsets. In that phase a bench reference model tracks the expected request and flag.

// File: rtl/batt_low_monitor_pkg.sv
package batt_low_monitor_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } monState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrInterval;  // restart tick count (power-up check)
    logic clrSettle;    // restart settle window count
    logic sampling;     // check window active
    logic latchResult;  // capture comparator result this edge
  } monStrobe_t;

endpackage

// File: rtl/batt_low_monitor_datapath.sv
module batt_low_monitor_datapath
  import batt_low_monitor_pkg::*;
#(
  parameter int INTERVAL_TICKS = 86400,
  parameter int SETTLE_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       tick,
  input  logic       battBelow,
  input  monStrobe_t strb,
  output logic       intervalHit,
  output logic       settleLast,
  output logic       flagLow
);

  localparam int IW = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;
  localparam int SW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [IW-1:0] INT_LAST = IW'(INTERVAL_TICKS - 1);
  localparam logic [SW-1:0] SET_LAST = SW'(SETTLE_CYCLES - 1);

  logic [IW-1:0] intervalCnt;
  logic [SW-1:0] settleCnt;

  // Interval tick counter: frozen and cleared without nominal supply
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (!supplyOk || strb.clrInterval) begin
      intervalCnt <= '0;
    end else if (tick) begin
      if (intervalCnt == INT_LAST) intervalCnt <= '0;
      else                         intervalCnt <= intervalCnt + 1'b1;
    end
  end

  assign intervalHit = supplyOk && tick && (intervalCnt == INT_LAST);

  // Settle window counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strb.clrSettle) begin
      settleCnt <= '0;
    end else if (strb.sampling && !settleLast) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  assign settleLast = (settleCnt == SET_LAST);

  // Sticky battery-low flag, written only by a completed check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagLow <= 1'b0;
    end else if (strb.latchResult) begin
      flagLow <= battBelow;
    end
  end

  a_r4_flag_only_on_latch: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchResult |=> $stable(flagLow));

  a_r6_count_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (intervalCnt == '0));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    intervalCnt <= INT_LAST);

  a_r3_latch_in_window: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchResult |-> (strb.sampling && settleLast));

endmodule

// File: rtl/batt_low_monitor_ctrl.sv
module batt_low_monitor_ctrl
  import batt_low_monitor_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       intervalHit,
  input  logic       settleLast,
  output monStrobe_t strb,
  output logic       sampleReq
);

  monState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_OFF: begin
        if (supplyOk) begin
          stateNext        = ST_CHECK;
          strb.clrInterval = 1'b1;
          strb.clrSettle   = 1'b1;
        end
      end
      ST_CHECK: begin
        strb.sampling = 1'b1;
        if (!supplyOk) begin
          stateNext = ST_OFF;
        end else if (settleLast) begin
          strb.latchResult = 1'b1;
          stateNext        = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!supplyOk) begin
          stateNext = ST_OFF;
        end else if (intervalHit) begin
          stateNext      = ST_CHECK;
          strb.clrSettle = 1'b1;
        end
      end
      default: stateNext = ST_OFF;
    endcase
  end

  assign sampleReq = (state == ST_CHECK);

  a_r6_off_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !sampleReq);

  a_r2_powerup_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && supplyOk) |=> sampleReq);

  a_r7_abort_no_latch: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReq && !supplyOk) |-> !strb.latchResult);

  a_r5_periodic_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && supplyOk && intervalHit) |=> sampleReq);

endmodule

// File: rtl/batt_low_monitor.sv
module batt_low_monitor
  import batt_low_monitor_pkg::*;
#(
  parameter int INTERVAL_TICKS = 86400,
  parameter int SETTLE_CYCLES  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic tick,
  input  logic battBelow,
  output logic sampleReq,
  output logic pullLowEn
);

  monStrobe_t strb;
  logic       intervalHit;
  logic       settleLast;
  logic       flagLow;

  batt_low_monitor_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .intervalHit(intervalHit),
    .settleLast (settleLast),
    .strb       (strb),
    .sampleReq  (sampleReq)
  );

  batt_low_monitor_datapath #(
    .INTERVAL_TICKS(INTERVAL_TICKS),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .tick       (tick),
    .battBelow  (battBelow),
    .strb       (strb),
    .intervalHit(intervalHit),
    .settleLast (settleLast),
    .flagLow    (flagLow)
  );

  // Open-drain: the pad only ever pulls low, enabled by the flag
  assign pullLowEn = flagLow;

endmodule

// File: tb/batt_low_monitor_test.sv
module batt_low_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_TICKS    = 5;
  localparam int N_SETTLE   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic tick = 1'b0;
  logic battBelow = 1'b0;
  logic sampleReq, pullLowEn;

  int checks = 0;
  int fails  = 0;
  bit modelOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_low_monitor #(.INTERVAL_TICKS(N_TICKS), .SETTLE_CYCLES(N_SETTLE)) uut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .tick(tick),
    .battBelow(battBelow), .sampleReq(sampleReq), .pullLowEn(pullLowEn)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Reference model built from the requirements: 0 off, 1 check, 2 run
  int  mState = 0;
  int  mLeft  = 0;
  int  mTicks = 0;
  logic mFlag = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mLeft = 0; mTicks = 0; mFlag = 1'b0;
    end else begin
      case (mState)
        0: if (supplyOk) begin mState = 1; mLeft = N_SETTLE; mTicks = 0; end
        1: begin
          if (!supplyOk) begin mState = 0; mTicks = 0; end
          else begin
            if (tick) mTicks = (mTicks == N_TICKS-1) ? 0 : mTicks + 1;
            if (mLeft == 1) begin mFlag = battBelow; mState = 2; end
            else mLeft = mLeft - 1;
          end
        end
        default: begin
          if (!supplyOk) begin mState = 0; mTicks = 0; end
          else if (tick) begin
            if (mTicks == N_TICKS-1) begin mTicks = 0; mState = 1; mLeft = N_SETTLE; end
            else mTicks = mTicks + 1;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      chk("R2/R5/R6/R7 model sampleReq", sampleReq, (mState == 1));
      chk("R3/R4/R8 model pullLowEn", pullLowEn, mFlag);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive supply up and run the power-up check; counts request cycles
  task automatic powerUp(input logic bb, output int reqCycles);
    reqCycles = 0;
    @(negedge clk);
    supplyOk = 1'b1; battBelow = bb; tick = 1'b0;
    for (int i = 0; i < N_SETTLE + 1; i++) begin
      @(negedge clk);
      if (sampleReq) reqCycles++;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    cyc(3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset sampleReq", sampleReq, 1'b0);
    chk("R1 reset pullLowEn", pullLowEn, 1'b0);
    modelOn = 1'b1;
    cyc(3);
    chk("R6 no request while unpowered", sampleReq, 1'b0);

    // Power-up with low battery
    powerUp(1'b1, n);
    chk("R2 request length", (n == N_SETTLE), 1'b1);
    chk("R2 request fell", sampleReq, 1'b0);
    chk("R3 low captured", pullLowEn, 1'b1);

    // Comparator changes outside a check, no ticks
    battBelow = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      battBelow = ~battBelow;
      chk("R9 no check without ticks", sampleReq, 1'b0);
      chk("R4 flag unaffected outside check", pullLowEn, 1'b1);
    end

    // Periodic check that passes
    battBelow = 1'b0;
    tick = 1'b1;
    cyc(N_TICKS - 1);
    chk("R5 no check before interval", sampleReq, 1'b0);
    @(negedge clk);
    tick = 1'b0;
    chk("R5 periodic check starts", sampleReq, 1'b1);
    cyc(N_SETTLE);
    chk("R8 periodic pass clears flag", pullLowEn, 1'b0);
    chk("R3 window closed", sampleReq, 1'b0);

    // Periodic check aborted by supply loss with low battery
    battBelow = 1'b1;
    tick = 1'b1;
    cyc(N_TICKS);
    tick = 1'b0;
    chk("R5 second periodic check", sampleReq, 1'b1);
    @(negedge clk);
    supplyOk = 1'b0;
    @(negedge clk);
    chk("R7 request drops on abort", sampleReq, 1'b0);
    cyc(N_SETTLE);
    chk("R7 flag kept after abort", pullLowEn, 1'b0);
    tick = 1'b1;
    for (int i = 0; i < 3 * N_TICKS; i++) begin
      @(negedge clk);
      chk("R6 no check while unpowered", sampleReq, 1'b0);
    end
    tick = 1'b0;

    // Low at power-up, then a passing power-up check clears it
    powerUp(1'b1, n);
    chk("R3 low at power-up", pullLowEn, 1'b1);
    @(negedge clk); supplyOk = 1'b0;
    cyc(2);
    chk("R6 flag held unpowered", pullLowEn, 1'b1);
    powerUp(1'b0, n);
    chk("R8 power-up pass clears flag", pullLowEn, 1'b0);
    chk("R2 second power-up length", (n == N_SETTLE), 1'b1);

    // Power-up restarts the interval count (R6): partial ticks, cycle, then count again
    tick = 1'b1; cyc(N_TICKS - 2); tick = 1'b0;
    supplyOk = 1'b0; cyc(2);
    powerUp(1'b0, n);
    tick = 1'b1; cyc(N_TICKS - 1);
    chk("R6 count restarted at power-up", sampleReq, 1'b0);
    @(negedge clk); tick = 1'b0;
    chk("R5 check after full interval", sampleReq, 1'b1);
    cyc(N_SETTLE + 1);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (supplyOk) supplyOk = ($urandom % 100) >= 3;
      else          supplyOk = ($urandom % 100) < 20;
      tick      = ($urandom % 100) < 40;
      battBelow = ($urandom % 2) == 1;
    end
    cyc(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule